// File: doc/BRIEF.md
# Two-Phase Page DMA Sequencer

This block moves one flash page between a flash data stream and system memory by staging it in a local page buffer. Every transfer is split into two phases that software enables one at a time: the internal phase exchanges the page with the flash data stream, and the memory phase exchanges it with memory through a simple request port. For a flash read, the internal phase runs first (flash to buffer) and the memory phase second (buffer to memory). For a flash write, the order is reversed. Each phase raises its own completion flag, so the interrupt handler knows when to program the other phase.

A small register port holds the direction and phase selection, the memory base address, the interrupt enables and a write-one-to-clear status register. A stage counter follows the operation. It goes from idle to the first phase, then to the gap between the phases, and then reaches a one-cycle done mark. An external fault or a write of an idle setting stops the engine at any point. Both flash streams use valid/ready handshakes. A word moves on a cycle where valid and ready are both high. The data source must hold valid and data stable until the word is accepted, and the sink may drop ready at any time. The memory port follows the same rule: the block holds a request until `mem_ready`, and `mem_rdata` is taken in the accepting cycle.

Top module: `pdma_seq`

## Requirements
- R1: A phase moves exactly one 512-byte page as 128 words of 32 bits, one word per handshake. After the 128th handshake the engine is no longer busy.
- R2: An internal phase with the read bit set raises `fl_in_ready` only while it runs. It stores the accepted words in order into the buffer.
- R3: An internal phase with the read bit clear presents buffer words in order on `fl_out_data` with `fl_out_valid`. It holds each word until `fl_out_ready` is high.
- R4: A memory phase with the read bit set issues writes (`mem_we`=1) of buffer word i to byte address base+4*i. It holds each request until `mem_ready` is high.
- R5: A memory phase with the read bit clear issues reads (`mem_we`=0) of base+4*i and stores `mem_rdata` into buffer word i. A later internal write phase then streams exactly those words.
- R6: The settings register is at address 0. Bit 0 selects read direction, bit 1 the internal phase and bit 2 the memory phase. A write with exactly one phase bit set starts that phase. A write with both phase bits set is ignored and sets the misuse flag.
- R7: The status register is at address 3. Bit 0 means internal phase done, bit 1 memory phase done, bit 2 error and bit 3 misuse. Writing ones clears those bits. `irq` is the OR of status bits 0..2, each ANDed with the same bit of the enable register at address 2.
- R8: `stage` is 0 when idle and becomes 1 when a phase starts from idle. The first completed phase moves it to 2, and the second to 3 for exactly one cycle, after which it returns to 0.
- R9: When `fault_in` is high during a phase, the phase stops, the error flag is set and `stage` returns to 0. A settings write with no phase bit set stops any phase and returns `stage` to 0.
- R10: The base address is at address 1. If a memory phase is started while base bits [8:0] are not zero, the error flag is set, `stage` returns to 0 and no memory request is issued.
- R11: A settings write with a phase bit set while a phase is busy leaves the settings unchanged and sets the sticky misuse flag.
- R12: The capability register is at address 4 and reads back the two capability bits in bits [1:0]. Unless both bits are set, no phase can be started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| fault_in | input | 1 | External fault, aborts a running phase |
| fl_in_valid | input | 1 | Flash-to-block word valid |
| fl_in_ready | output | 1 | Block accepts a flash word |
| fl_in_data | input | 32 | Flash-to-block word |
| fl_out_valid | output | 1 | Block-to-flash word valid |
| fl_out_ready | input | 1 | Flash accepts the word |
| fl_out_data | output | 32 | Block-to-flash word |
| mem_valid | output | 1 | Memory request pending |
| mem_ready | input | 1 | Memory accepts the request |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid in the accepting cycle |
| busy | output | 1 | A phase is running |
| stage | output | 2 | Operation stage count |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that software writes the settings register only when no phase is busy, unless the write is deliberate misuse. They also assume that a status clear never coincides with a settings write, because the register port carries one access per cycle. The stimulus holds `fl_in_valid` and its data until the word is accepted. It toggles the ready inputs freely, so that every phase runs under back-pressure. Faults, misuse writes and unaligned bases are issued only at chosen points. A behavioural model follows every cycle, including the cycle where an abort falls on a running phase.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  typedef enum logic [2:0] {
    RA_SET  = 3'd0,
    RA_BASE = 3'd1,
    RA_IEN  = 3'd2,
    RA_ISTA = 3'd3,
    RA_CAP  = 3'd4
  } reg_addr_e;

  localparam int SB_RD  = 0;
  localparam int SB_INT = 1;
  localparam int SB_MEM = 2;

  localparam int ST_INT = 0;
  localparam int ST_MEM = 1;
  localparam int ST_ERR = 2;
  localparam int ST_MIS = 3;

  localparam logic [1:0] STG_IDLE = 2'd0;
  localparam logic [1:0] STG_ONE  = 2'd1;
  localparam logic [1:0] STG_TWO  = 2'd2;
  localparam logic [1:0] STG_DONE = 2'd3;
endpackage

// File: rtl/pdma_page_buf.sv
module pdma_page_buf #(
  parameter int DW    = 32,
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];
endmodule

// File: rtl/pdma_engine.sv
module pdma_engine #(
  parameter int DW         = 32,
  parameter int AW         = 32,
  parameter int PAGE_BYTES = 512,
  localparam int WORDS     = PAGE_BYTES / (DW / 8),
  localparam int IW        = $clog2(WORDS),
  localparam int SHIFT     = $clog2(DW / 8),
  localparam int OFF       = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_mem,
  input  logic          start_rd,
  input  logic [AW-1:0] start_base,
  input  logic          abort,
  output logic          busy,
  output logic          phase_mem,
  output logic          done,
  input  logic          fl_in_valid,
  output logic          fl_in_ready,
  input  logic [DW-1:0] fl_in_data,
  output logic          fl_out_valid,
  input  logic          fl_out_ready,
  output logic [DW-1:0] fl_out_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          buf_we,
  output logic [IW-1:0] buf_idx,
  output logic [DW-1:0] buf_wdata,
  input  logic [DW-1:0] buf_rdata
);
  logic          busy_q, mem_q, rd_q;
  logic [IW-1:0] idx_q;
  logic [AW-1:0] base_q;
  logic          hs, last;

  assign hs   = busy_q && (mem_q ? mem_ready : (rd_q ? fl_in_valid : fl_out_ready));
  assign last = (idx_q == IW'(WORDS - 1));
  assign done = hs && last && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      mem_q  <= 1'b0;
      rd_q   <= 1'b0;
      idx_q  <= '0;
      base_q <= '0;
    end else if (abort) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
      mem_q  <= start_mem;
      rd_q   <= start_rd;
      base_q <= start_base;
    end else if (hs) begin
      idx_q <= idx_q + 1'b1;
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy         = busy_q;
  assign phase_mem    = mem_q;
  assign fl_in_ready  = busy_q && !mem_q && rd_q;
  assign fl_out_valid = busy_q && !mem_q && !rd_q;
  assign fl_out_data  = buf_rdata;
  assign mem_valid    = busy_q && mem_q;
  assign mem_we       = rd_q;
  assign mem_addr     = base_q + (AW'(idx_q) << SHIFT);
  assign mem_wdata    = buf_rdata;
  assign buf_idx      = idx_q;
  assign buf_we       = hs && !abort && (mem_q != rd_q);
  assign buf_wdata    = mem_q ? mem_rdata : fl_in_data;

  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
  p_req_aligned_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (base_q[OFF-1:0] == '0));
endmodule

// File: rtl/pdma_ctrl.sv
module pdma_ctrl
  import pdma_pkg::*;
#(
  parameter int         AW         = 32,
  parameter int         PAGE_BYTES = 512,
  parameter logic [1:0] CAP        = 2'b11,
  localparam int        OFF        = $clog2(PAGE_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fault_in,
  input  logic          busy,
  input  logic          phase_mem,
  input  logic          done,
  output logic          start,
  output logic          abort,
  output logic [AW-1:0] base,
  output logic          set_rd,
  output logic          set_mem,
  output logic [1:0]    stage,
  output logic          irq
);
  logic [2:0]    set_q, en_q;
  logic [3:0]    sta_q, sta_set, sta_clr;
  logic [AW-1:0] base_q;
  logic [1:0]    stage_q, phases;
  logic          cmd_wr, idle_wr, fault_abort, bad_wr, good_wr, misalign, usable;

  assign usable      = &CAP;
  assign cmd_wr      = reg_we && (reg_addr == RA_SET);
  assign phases      = reg_wdata[SB_MEM:SB_INT];
  assign idle_wr     = cmd_wr && (phases == 2'b00);
  assign fault_abort = fault_in && busy;
  assign abort       = idle_wr || fault_abort;
  assign bad_wr      = cmd_wr && (phases != 2'b00) && (busy || (phases == 2'b11) || !usable);
  assign good_wr     = cmd_wr && (phases != 2'b00) && !bad_wr;
  assign misalign    = good_wr && reg_wdata[SB_MEM] && (base_q[OFF-1:0] != '0);
  assign start       = good_wr && !misalign;

  assign sta_clr = (reg_we && (reg_addr == RA_ISTA)) ? reg_wdata[3:0] : 4'b0;
  always_comb begin
    sta_set         = '0;
    sta_set[ST_INT] = done && !phase_mem;
    sta_set[ST_MEM] = done && phase_mem;
    sta_set[ST_ERR] = fault_abort || misalign;
    sta_set[ST_MIS] = bad_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_q   <= '0;
      en_q    <= '0;
      sta_q   <= '0;
      base_q  <= '0;
      stage_q <= STG_IDLE;
    end else begin
      sta_q <= (sta_q & ~sta_clr) | sta_set;
      if (reg_we && (reg_addr == RA_BASE)) base_q <= reg_wdata[AW-1:0];
      if (reg_we && (reg_addr == RA_IEN))  en_q   <= reg_wdata[2:0];

      if (idle_wr)                       set_q <= reg_wdata[2:0];
      else if (fault_abort || misalign)  set_q <= '0;
      else if (start)                    set_q <= reg_wdata[2:0];
      else if (done)                     set_q <= {2'b00, set_q[SB_RD]};

      if (abort || misalign)
        stage_q <= STG_IDLE;
      else if (start && (stage_q == STG_IDLE || stage_q == STG_DONE))
        stage_q <= STG_ONE;
      else if (done && stage_q == STG_ONE)
        stage_q <= STG_TWO;
      else if (done && stage_q == STG_TWO)
        stage_q <= STG_DONE;
      else if (stage_q == STG_DONE)
        stage_q <= STG_IDLE;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_SET:  reg_rdata[2:0]    = set_q;
      RA_BASE: reg_rdata[AW-1:0] = base_q;
      RA_IEN:  reg_rdata[2:0]    = en_q;
      RA_ISTA: reg_rdata[3:0]    = sta_q;
      RA_CAP:  reg_rdata[1:0]    = CAP;
      default: reg_rdata         = '0;
    endcase
  end

  assign base    = base_q;
  assign set_rd  = reg_wdata[SB_RD];
  assign set_mem = reg_wdata[SB_MEM];
  assign stage   = stage_q;
  assign irq     = |(sta_q[2:0] & en_q);

  p_one_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_q[SB_MEM:SB_INT]));
  p_stage_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (stage_q == STG_DONE) |=> (stage_q != STG_DONE));
  p_fault_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in && busy) |=> !busy);
  p_misuse_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy && (phases != 2'b00)) |=> sta_q[ST_MIS]);
endmodule

// File: rtl/pdma_seq.sv
module pdma_seq
  import pdma_pkg::*;
#(
  parameter int         DW         = 32,
  parameter int         AW         = 32,
  parameter int         PAGE_BYTES = 512,
  parameter logic [1:0] CAP        = 2'b11,
  localparam int        WORDS      = PAGE_BYTES / (DW / 8),
  localparam int        IW         = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fault_in,
  input  logic          fl_in_valid,
  output logic          fl_in_ready,
  input  logic [DW-1:0] fl_in_data,
  output logic          fl_out_valid,
  input  logic          fl_out_ready,
  output logic [DW-1:0] fl_out_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          busy,
  output logic [1:0]    stage,
  output logic          irq
);
  logic          start, abort, set_rd, set_mem, phase_mem, done, buf_we;
  logic [AW-1:0] base;
  logic [IW-1:0] buf_idx;
  logic [DW-1:0] buf_wdata, buf_rdata;

  pdma_ctrl #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .CAP(CAP)) u_ctrl (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .fault_in,
    .busy, .phase_mem, .done, .start, .abort, .base, .set_rd, .set_mem,
    .stage, .irq
  );

  pdma_engine #(.DW(DW), .AW(AW), .PAGE_BYTES(PAGE_BYTES)) u_eng (
    .clk, .rst_n, .start, .start_mem(set_mem), .start_rd(set_rd),
    .start_base(base), .abort, .busy, .phase_mem, .done,
    .fl_in_valid, .fl_in_ready, .fl_in_data, .fl_out_valid, .fl_out_ready,
    .fl_out_data, .mem_valid, .mem_ready, .mem_we, .mem_addr, .mem_wdata,
    .mem_rdata, .buf_we, .buf_idx, .buf_wdata, .buf_rdata
  );

  pdma_page_buf #(.DW(DW), .DEPTH(WORDS)) u_buf (
    .clk, .wr_en(buf_we), .wr_idx(buf_idx), .wr_data(buf_wdata),
    .rd_idx(buf_idx), .rd_data(buf_rdata)
  );
endmodule

// File: tb/sim_pdma_seq.sv
module sim_pdma_seq;
  localparam int CLK_NS = 10;
  localparam int WORDS  = 128;
  localparam int LIMIT  = 150000;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0, fault_in = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        fl_in_valid = 1'b0, fl_out_ready = 1'b0, mem_ready = 1'b0;
  logic [31:0] fl_in_data = '0;
  logic [31:0] reg_rdata, fl_out_data, mem_addr, mem_wdata, mem_rdata;
  logic        fl_in_ready, fl_out_valid, mem_valid, mem_we, busy, irq;
  logic [1:0]  stage;
  logic [31:0] x_rdata, x_fod, x_maddr, x_mwd;
  logic        x_fir, x_fov, x_mv, x_mwe, x_busy, x_irq;
  logic [1:0]  x_stage;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0, seen3 = 0;

  function automatic logic [31:0] mem_pat(logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  assign mem_rdata = mem_pat(mem_addr);

  always #(CLK_NS/2) clk = ~clk;

  pdma_seq u0 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .fault_in,
    .fl_in_valid, .fl_in_ready, .fl_in_data, .fl_out_valid, .fl_out_ready, .fl_out_data,
    .mem_valid, .mem_ready, .mem_we, .mem_addr, .mem_wdata, .mem_rdata, .busy, .stage, .irq);

  pdma_seq #(.CAP(2'b01)) u1 (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata(x_rdata),
    .fault_in, .fl_in_valid, .fl_in_ready(x_fir), .fl_in_data, .fl_out_valid(x_fov),
    .fl_out_ready, .fl_out_data(x_fod), .mem_valid(x_mv), .mem_ready, .mem_we(x_mwe),
    .mem_addr(x_maddr), .mem_wdata(x_mwd), .mem_rdata, .busy(x_busy), .stage(x_stage), .irq(x_irq));

  // behavioural reference model
  logic        m_busy, m_mem, m_rd, m_in_hs;
  logic [6:0]  m_idx;
  logic [1:0]  m_stage;
  logic [3:0]  m_sta;
  logic [2:0]  m_en, m_set;
  logic [31:0] m_base, m_bq;
  logic [31:0] m_buf [WORDS];
  logic [31:0] q_in[$], q_mem[$], q_rdmem[$], q_out[$];

  always @(posedge clk) begin
    logic hs, cmd, idle_wr, fab, ab, bad, good, mis, dn;
    logic [1:0] ph, ns;
    logic [3:0] clr, setb;
    logic [31:0] addr;
    if (!rst_n) begin
      m_busy = 0; m_mem = 0; m_rd = 0; m_idx = 0; m_stage = 0; m_sta = 0;
      m_en = 0; m_set = 0; m_base = 0; m_bq = 0; m_in_hs = 0;
    end else begin
      addr = m_bq + {23'd0, m_idx, 2'b00};
      hs = m_busy && (m_mem ? mem_ready : (m_rd ? fl_in_valid : fl_out_ready));
      m_in_hs = hs && !m_mem && m_rd;
      cmd = reg_we && reg_addr == 3'd0;
      ph = cmd ? reg_wdata[2:1] : 2'b00;
      idle_wr = cmd && ph == 2'b00;
      fab = fault_in && m_busy;
      ab = idle_wr || fab;
      bad = cmd && ph != 0 && (m_busy || ph == 2'b11);
      good = cmd && ph != 0 && !bad;
      mis = good && ph[1] && m_base[8:0] != 0;
      dn = hs && m_idx == 7'd127 && !ab;
      if (hs && !ab && !m_mem && m_rd) q_in.push_back(fl_in_data);
      if (hs && !ab && m_mem && !m_rd) q_rdmem.push_back(mem_pat(addr));
      if (hs && !ab && (m_mem != m_rd)) m_buf[m_idx] = m_mem ? mem_pat(addr) : fl_in_data;
      clr = (reg_we && reg_addr == 3'd3) ? reg_wdata[3:0] : 4'b0;
      setb = {bad, fab || mis, dn && m_mem, dn && !m_mem};
      ns = (m_stage == 2'd3) ? 2'd0 : m_stage;
      if (ab || mis) ns = 0;
      else if (good && (m_stage == 0 || m_stage == 3)) ns = 1;
      else if (dn) ns = (m_stage == 2) ? 2'd3 : ((m_stage == 1) ? 2'd2 : m_stage);
      if (idle_wr) m_set = reg_wdata[2:0];
      else if (fab || mis) m_set = 0;
      else if (good) m_set = reg_wdata[2:0];
      else if (dn) m_set = {2'b00, m_set[0]};
      if (ab) begin m_busy = 0; m_idx = 0; end
      else if (good && !mis) begin
        m_busy = 1; m_idx = 0; m_mem = reg_wdata[2]; m_rd = reg_wdata[0]; m_bq = m_base;
      end else if (hs) begin
        if (m_idx == 7'd127) begin m_busy = 0; m_idx = 0; end
        else m_idx = m_idx + 1;
      end
      m_stage = ns;
      m_sta = (m_sta & ~clr) | setb;
      if (reg_we && reg_addr == 3'd1) m_base = reg_wdata;
      if (reg_we && reg_addr == 3'd2) m_en = reg_wdata[2:0];
    end
  end

  // capture DUT handshakes (pre-edge values)
  always @(posedge clk) if (rst_n) begin
    if (mem_valid && mem_ready && mem_we) q_mem.push_back(mem_wdata);
    if (fl_out_valid && fl_out_ready) q_out.push_back(fl_out_data);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) if (rst_n && !done_flag) begin
    if (m_stage == 2'd3) seen3 = 1;
    chk("R8 busy", {31'd0, busy}, {31'd0, m_busy});
    chk("R8 stage", {30'd0, stage}, {30'd0, m_stage});
    chk("R7 irq", {31'd0, irq}, {31'd0, |(m_sta[2:0] & m_en)});
    chk("R2 fl_in_ready", {31'd0, fl_in_ready}, {31'd0, m_busy && !m_mem && m_rd});
    chk("R3 fl_out_valid", {31'd0, fl_out_valid}, {31'd0, m_busy && !m_mem && !m_rd});
    if (m_busy && !m_mem && !m_rd) chk("R3 fl_out_data", fl_out_data, m_buf[m_idx]);
    chk("R10 mem_valid", {31'd0, mem_valid}, {31'd0, m_busy && m_mem});
    if (m_busy && m_mem) begin
      chk("R4/R5 mem_addr", mem_addr, m_bq + {23'd0, m_idx, 2'b00});
      chk("R4/R5 mem_we", {31'd0, mem_we}, {31'd0, m_rd});
      if (m_rd) chk("R4 mem_wdata", mem_wdata, m_buf[m_idx]);
    end
    chk("R12 no start without capability", {31'd0, x_busy}, 32'd0);
  end

  // stream and memory-side stimulus
  always @(negedge clk) begin
    #1;
    if (!fl_in_valid || m_in_hs) begin
      fl_in_valid = ($urandom % 4) != 0;
      fl_in_data  = $urandom;
    end
    fl_out_ready = ($urandom % 3) != 0;
    mem_ready    = ($urandom % 4) != 0;
  end

  task automatic summary();
    done_flag = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !done_flag) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, LIMIT);
      summary();
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    @(negedge clk); #2;
    reg_addr = a; #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && m_busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    rd("R12 cap", 3'd4, 32'd3);
    rd("R12 cap unusable", 3'd4, 32'd3);
    chk("R12 cap u1", x_rdata, 32'd1);
    rd("R7 status reset", 3'd3, 32'd0);
    chk("R8 stage reset", {30'd0, stage}, 32'd0);
    wr(3'd2, 32'd7);
    // flash read: internal then memory
    wr(3'd1, 32'h0000_1000);
    wr(3'd0, 32'd3);
    wait_idle();
    rd("R2 internal done flag", 3'd3, 32'd1);
    chk("R8 stage after first phase", {30'd0, stage}, 32'd2);
    chk("R7 irq raised", {31'd0, irq}, 32'd1);
    wr(3'd3, 32'd1);
    rd("R7 w1c clear", 3'd3, 32'd0);
    chk("R7 irq dropped", {31'd0, irq}, 32'd0);
    seen3 = 0;
    wr(3'd0, 32'd5);
    wait_idle();
    rd("R4 memory done flag", 3'd3, 32'd2);
    chk("R8 done mark seen", {31'd0, seen3}, 32'd1);
    chk("R8 stage back to idle", {30'd0, stage}, 32'd0);
    chk("R1 words in", q_in.size(), WORDS);
    chk("R1 words to memory", q_mem.size(), WORDS);
    for (int i = 0; i < WORDS && i < q_mem.size() && i < q_in.size(); i++)
      chk("R4 page order", q_mem[i], q_in[i]);
    // flash write: memory then internal
    wr(3'd3, 32'hF);
    wr(3'd1, 32'h0000_2000);
    wr(3'd0, 32'd4);
    wait_idle();
    rd("R5 memory done flag", 3'd3, 32'd2);
    wr(3'd0, 32'd2);
    wait_idle();
    rd("R3 both flags", 3'd3, 32'd3);
    chk("R1 words out", q_out.size(), WORDS);
    for (int i = 0; i < WORDS && i < q_out.size(); i++)
      chk("R5 streamed page", q_out[i], mem_pat(32'h2000 + 32'(i * 4)));
    // misuse while busy, then idle write
    wr(3'd3, 32'hF);
    wr(3'd0, 32'd3);
    repeat (3) @(negedge clk);
    wr(3'd0, 32'd5);
    rd("R11 settings unchanged", 3'd0, 32'd3);
    rd("R11 misuse flag", 3'd3, 32'd8);
    chk("R11 still busy", {31'd0, busy}, 32'd1);
    wr(3'd0, 32'd0);
    chk("R9 idle write stops", {31'd0, busy}, 32'd0);
    chk("R9 stage idle", {30'd0, stage}, 32'd0);
    // both phase bits
    wr(3'd3, 32'hF);
    wr(3'd0, 32'd6);
    rd("R6 both bits misuse", 3'd3, 32'd8);
    chk("R6 no start", {31'd0, busy}, 32'd0);
    // unaligned base
    wr(3'd3, 32'hF);
    wr(3'd1, 32'h0000_1010);
    wr(3'd0, 32'd5);
    rd("R10 error flag", 3'd3, 32'd4);
    chk("R10 no request", {31'd0, mem_valid}, 32'd0);
    chk("R10 stage idle", {30'd0, stage}, 32'd0);
    // fault during a phase
    wr(3'd3, 32'hF);
    wr(3'd1, 32'h0000_3000);
    wr(3'd0, 32'd3);
    repeat (5) @(negedge clk);
    #1 fault_in = 1;
    @(negedge clk); #1 fault_in = 0;
    rd("R9 fault error flag", 3'd3, 32'd4);
    chk("R9 fault stops", {31'd0, busy}, 32'd0);
    chk("R9 fault stage", {30'd0, stage}, 32'd0);
    wr(3'd2, 32'd0);
    @(negedge clk);
    chk("R7 masked irq", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'hF);
    repeat (3) @(negedge clk);
    summary();
  end
endmodule